// File: doc/BRIEF.md
# Time-Shared Multi-Level Pyramid Filter

This block builds a three-level image pyramid from one raster-order pixel stream while owning a single 3x3 smoothing datapath. Pixels of the finest image arrive on a valid/ready input. Each pyramid level has a small rolling row store of four rows, and each store is half as wide as the level above it. A fixed 21-slot schedule repeats without pause. It hands the one filter datapath to the coarsest level for one slot, to the middle level for four slots and to the finest level for sixteen slots. In each slot the selected level's 3x3 neighbourhood is read out, weighted and rounded. If that level cannot yet produce a pixel, the slot goes unused.

Every filtered pixel leaves on one output bus with a level tag and a frame-start flag. A filtered pixel that sits on an even row and an even column of its level is also written into the next coarser level, so each coarser level works on a 2x-decimated copy of the smoothed finer one. Frames stream back to back. The finest level accepts a new frame once it has finished filtering the previous one.

Top module: `pyr_ts_engine`

## Requirements
- R1: One filter datapath serves all levels. At most one filtered pixel is produced per clock, and each frame yields exactly W*H + (W/2)*(H/2) + (W/4)*(H/4) output beats, with no duplicates.
- R2: `out_level_o` is 0 for the finest level, 1 for the middle level and 2 for the coarsest level. A beat's tag equals the level that owned the slot in which the pixel was computed. The beat appears one clock after that slot.
- R3: The slot index starts at 0 in the first clock after reset and advances by one each clock, wrapping from 20 back to 0. Slot 0 belongs to level 2, slots 1 to 4 belong to level 1, and slots 5 to 20 belong to level 0.
- R4: An interior output pixel equals (sum of the 3x3 neighbours weighted 1,2,1 / 2,4,2 / 1,2,1, plus 8) shifted right by 4.
- R5: At image borders, a neighbour outside the image takes the value of the nearest edge pixel of the same row or column (clamped coordinates).
- R6: Level k+1 is (W>>(k+1)) by (H>>(k+1)) pixels. Its input pixel (r,c) is level k's filtered pixel (2r,2c), and it is filtered with the same rule.
- R7: A level emits nothing until its window is complete. Finest-level output (r,c) of a frame appears only after input rows 0 to min(r+1,H-1) of that frame have been accepted.
- R8: `pix_ready_o` is high exactly when the finest level is working on the current input frame and the incoming pixel's row is at most two rows ahead of the row being filtered. A new frame is held off until the finest level has filtered the whole previous frame.
- R9: `out_sof_o` is 1 on the first beat of each level in each frame, and 0 on every other beat.
- R10: While reset is held, `out_valid_o` is 0 and `pix_ready_o` is 1.
- R11: Consecutive frames are processed in order at every level, and no level emits beyond the frames supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_data_i | input | PIX_W | Finest-level pixel, raster order |
| pix_ready_o | output | 1 | Input pixel accepted when high with valid |
| out_valid_o | output | 1 | Filtered pixel valid |
| out_data_o | output | PIX_W | Filtered pixel |
| out_level_o | output | 2 | Level of the beat, 0 = finest |
| out_sof_o | output | 1 | First beat of its level in a frame |

## Verification
The bench targets the four image borders and corners, where a wrong clamp makes edge pixels pick up stale rows from the rolling store or neighbours from the adjacent row. A frame that is all 255 shows whether the rounding add overflows the sum, and an alternating 0/255 pattern shows rounding off by one. For the coarser levels it checks whether the wrong filtered pixels are kept during decimation or whether frame boundaries leak between levels. On the timing side, every beat is compared with the slot that should own it, and the ready signal is predicted cycle by cycle. An early window release or an overwrite of a row that is still in use then appears as a mismatch.

// File: rtl/pyr_pkg.sv
`timescale 1ns/1ps
package pyr_pkg;
  localparam int unsigned LVL_W = 2;

  // slots owned by a level per schedule round; coarsest owns one
  function automatic int unsigned lvl_slots(int unsigned levels, int unsigned lvl);
    return 32'd1 << (2 * (levels - 1 - lvl));
  endfunction

  // first slot of a level; coarser levels come first
  function automatic int unsigned lvl_base(int unsigned levels, int unsigned lvl);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = lvl + 1; k < levels; k++) acc += lvl_slots(levels, k);
    return acc;
  endfunction

  function automatic int unsigned total_slots(int unsigned levels);
    return lvl_base(levels, 0) + lvl_slots(levels, 0);
  endfunction

  function automatic int unsigned owner_of(int unsigned levels, int unsigned slot);
    int unsigned o;
    o = 0;
    for (int unsigned k = 0; k < levels; k++)
      if (slot >= lvl_base(levels, k) && slot < lvl_base(levels, k) + lvl_slots(levels, k)) o = k;
    return o;
  endfunction
endpackage

// File: rtl/pyr_slot_sched.sv
`timescale 1ns/1ps
module pyr_slot_sched import pyr_pkg::*; #(
  parameter int unsigned LEVELS = 3,
  localparam int unsigned SLOTS  = total_slots(LEVELS),
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              slot_q <= '0;
    else if (slot_q == SLOT_W'(SLOTS - 1))    slot_q <= '0;
    else                                      slot_q <= slot_q + SLOT_W'(1);
  end

  always_comb begin
    lvl_o = '0;
    for (int unsigned k = 0; k < LEVELS; k++)
      if (32'(slot_q) >= lvl_base(LEVELS, k) &&
          32'(slot_q) <  lvl_base(LEVELS, k) + lvl_slots(LEVELS, k))
        lvl_o = LVL_W'(k);
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/pyr_level_buf.sv
`timescale 1ns/1ps
module pyr_level_buf #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LW    = 16,
  parameter int unsigned LH    = 16,
  localparam int unsigned CW   = (LW > 1) ? $clog2(LW) : 1,
  localparam int unsigned RW   = $clog2(LH + 4)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [PIX_W-1:0]       wr_data_i,
  input  logic                   rd_fire_i,
  output logic                   can_wr_o,
  output logic                   avail_o,
  output logic                   keep_o,
  output logic                   first_o,
  output logic [8:0][PIX_W-1:0]  taps_o
);
  // four rolling rows: three in the window, one being filled
  logic [PIX_W-1:0] mem_q [4][LW];
  logic [RW-1:0]    wr_row_q, rd_row_q;
  logic [CW-1:0]    wr_col_q, rd_col_q;
  logic             rd_last_col, rd_last_row;
  logic [RW-1:0]    rsel [3];
  logic [CW-1:0]    csel [3];

  assign rd_last_col = (rd_col_q == CW'(LW - 1));
  assign rd_last_row = (rd_row_q == RW'(LH - 1));

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_row_q[1:0]][wr_col_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_row_q <= '0;
      wr_col_q <= '0;
      rd_row_q <= '0;
      rd_col_q <= '0;
    end else begin
      if (wr_en_i) begin
        if (wr_col_q == CW'(LW - 1)) begin
          wr_col_q <= '0;
          wr_row_q <= wr_row_q + RW'(1);
        end else begin
          wr_col_q <= wr_col_q + CW'(1);
        end
      end
      if (rd_fire_i) begin
        if (rd_last_col) begin
          rd_col_q <= '0;
          if (rd_last_row) begin
            rd_row_q <= '0;
            wr_row_q <= '0;  // frame retired, reopen writes
          end else begin
            rd_row_q <= rd_row_q + RW'(1);
          end
        end else begin
          rd_col_q <= rd_col_q + CW'(1);
        end
      end
    end
  end

  assign can_wr_o = (wr_row_q < RW'(LH)) && (wr_row_q <= rd_row_q + RW'(2));
  assign avail_o  = (wr_row_q == RW'(LH)) || (wr_row_q >= rd_row_q + RW'(2));
  assign keep_o   = ~rd_row_q[0] & ~rd_col_q[0];
  assign first_o  = (rd_row_q == '0) && (rd_col_q == '0);

  // edge replication by clamped coordinates
  always_comb begin
    rsel[0] = (rd_row_q == '0) ? rd_row_q : rd_row_q - RW'(1);
    rsel[1] = rd_row_q;
    rsel[2] = rd_last_row ? rd_row_q : rd_row_q + RW'(1);
    csel[0] = (rd_col_q == '0) ? rd_col_q : rd_col_q - CW'(1);
    csel[1] = rd_col_q;
    csel[2] = rd_last_col ? rd_col_q : rd_col_q + CW'(1);
  end

  for (genvar i = 0; i < 3; i++) begin : g_r
    for (genvar j = 0; j < 3; j++) begin : g_c
      assign taps_o[3*i+j] = mem_q[rsel[i][1:0]][csel[j]];
    end
  end
endmodule

// File: rtl/pyr_conv_pe.sv
`timescale 1ns/1ps
module pyr_conv_pe #(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned SUM_W = PIX_W + 4
) (
  input  logic [8:0][PIX_W-1:0] taps_i,
  output logic [PIX_W-1:0]      pix_o
);
  logic [SUM_W-1:0] term [9];
  logic [SUM_W-1:0] sum;

  for (genvar i = 0; i < 3; i++) begin : g_r
    for (genvar j = 0; j < 3; j++) begin : g_c
      localparam int unsigned SH = ((i == 1) ? 1 : 0) + ((j == 1) ? 1 : 0);
      assign term[3*i+j] = SUM_W'(taps_i[3*i+j]) << SH;
    end
  end

  // weights total 16; +8 rounds half up; max 16*max+8 fits SUM_W
  always_comb begin
    sum = SUM_W'(8);
    for (int k = 0; k < 9; k++) sum = sum + term[k];
  end

  assign pix_o = PIX_W'(sum >> 4);
endmodule

// File: rtl/pyr_ts_engine.sv
`timescale 1ns/1ps
module pyr_ts_engine import pyr_pkg::*; #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned IMG_W  = 16,
  parameter int unsigned IMG_H  = 16,
  parameter int unsigned LEVELS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  output logic              pix_ready_o,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  out_data_o,
  output logic [LVL_W-1:0]  out_level_o,
  output logic              out_sof_o
);
  localparam int unsigned SLOTS  = total_slots(LEVELS);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0]      slot_q;
  logic [LVL_W-1:0]       sel_lvl;
  logic [LEVELS-1:0]      fire, avail, can_wr, keep, first, dn_rdy, wr_en;
  logic [8:0][PIX_W-1:0]  taps [LEVELS];
  logic [PIX_W-1:0]       wr_data [LEVELS];
  logic [8:0][PIX_W-1:0]  pe_taps;
  logic [PIX_W-1:0]       pe_pix;

  pyr_slot_sched #(.LEVELS(LEVELS)) u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot_q),
    .lvl_o  (sel_lvl)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    if (l == 0) begin : g_src
      assign wr_en[l]   = pix_valid_i & can_wr[l];
      assign wr_data[l] = pix_data_i;
    end else begin : g_dec
      assign wr_en[l]   = fire[l-1] & keep[l-1];
      assign wr_data[l] = pe_pix;
    end

    if (l == LEVELS - 1) begin : g_top
      assign dn_rdy[l] = 1'b1;
    end else begin : g_mid
      assign dn_rdy[l] = can_wr[l+1];
    end

    // idle slot unless window complete and decimated result has a home
    assign fire[l] = (sel_lvl == LVL_W'(l)) & avail[l] & (~keep[l] | dn_rdy[l]);

    pyr_level_buf #(
      .PIX_W (PIX_W),
      .LW    (IMG_W >> l),
      .LH    (IMG_H >> l)
    ) u_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en[l]),
      .wr_data_i (wr_data[l]),
      .rd_fire_i (fire[l]),
      .can_wr_o  (can_wr[l]),
      .avail_o   (avail[l]),
      .keep_o    (keep[l]),
      .first_o   (first[l]),
      .taps_o    (taps[l])
    );
  end

  // timing mux onto the shared datapath
  always_comb begin
    pe_taps = '0;
    for (int unsigned k = 0; k < LEVELS; k++)
      if (sel_lvl == LVL_W'(k)) pe_taps = taps[k];
  end

  pyr_conv_pe #(.PIX_W(PIX_W)) u_pe (
    .taps_i (pe_taps),
    .pix_o  (pe_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_level_o <= '0;
      out_sof_o   <= 1'b0;
    end else begin
      out_valid_o <= |fire;
      out_data_o  <= pe_pix;
      out_level_o <= sel_lvl;
      out_sof_o   <= |(fire & first);
    end
  end

  assign pix_ready_o = can_wr[0];
endmodule

// File: rtl/pyr_ts_engine_chk.sv
`timescale 1ns/1ps
module pyr_ts_engine_chk import pyr_pkg::*; #(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned SLOTS  = 21,
  parameter int unsigned SLOT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] slot_q,
  input logic [LEVELS-1:0] fire,
  input logic              out_valid_o,
  input logic              out_sof_o,
  input logic [LVL_W-1:0]  out_level_o
);
  logic [LVL_W-1:0] owner;
  assign owner = LVL_W'(owner_of(LEVELS, 32'(slot_q)));

  assert_slot_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q == SLOT_W'(SLOTS - 1) |=> slot_q == '0);

  assert_slot_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q != SLOT_W'(SLOTS - 1) |=> slot_q == $past(slot_q) + SLOT_W'(1));

  assert_single_pe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire));

  assert_tag_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_level_o == $past(owner));

  assert_sof_on_beat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_valid_o);
endmodule

bind pyr_ts_engine pyr_ts_engine_chk #(
  .LEVELS (LEVELS),
  .SLOTS  (SLOTS),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_q      (slot_q),
  .fire        (fire),
  .out_valid_o (out_valid_o),
  .out_sof_o   (out_sof_o),
  .out_level_o (out_level_o)
);

// File: tb/pyr_ts_engine_bench.sv
`timescale 1ns/1ps
module pyr_ts_engine_bench;
  localparam int W = 16, H = 16, L = 3, NF = 4, NPIX = W * H, SLOTS = 21;
  localparam int BEATS_PER_FRAME = NPIX + NPIX / 4 + NPIX / 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0, pix_valid_i = 1'b0;
  logic [7:0] pix_data_i = '0;
  logic       pix_ready_o, out_valid_o, out_sof_o;
  logic [7:0] out_data_o;
  logic [1:0] out_level_o;

  int checks = 0, fails = 0;
  int src_v [NF][NPIX];
  int exp_v [NF][L][NPIX];
  int img   [L][NPIX];
  int fr [L];
  int ix [L];
  int beats = 0, acc_tot = 0, acc_seen = 0, edge_n = 0, cyc = 0;
  bit finished = 0, wd_hit = 0;

  pyr_ts_engine u_pyr_ts_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .pix_ready_o (pix_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_level_o (out_level_o),
    .out_sof_o   (out_sof_o)
  );

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) edge_n <= edge_n + 1;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int tap(int l, int w, int h, int r, int c);
    int rr, cc;
    rr = (r < 0) ? 0 : ((r >= h) ? h - 1 : r);
    cc = (c < 0) ? 0 : ((c >= w) ? w - 1 : c);
    return img[l][rr * w + cc];
  endfunction

  function automatic int filt(int l, int w, int h, int r, int c);
    int s;
    s = 8;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        s += tap(l, w, h, r + dr, c + dc) * ((dr == 0) ? 2 : 1) * ((dc == 0) ? 2 : 1);
    return s >> 4;
  endfunction

  task automatic build(int f);
    int w, h, v;
    for (int p = 0; p < NPIX; p++) img[0][p] = src_v[f][p];
    for (int l = 0; l < L; l++) begin
      w = W >> l;
      h = H >> l;
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          v = filt(l, w, h, r, c);
          exp_v[f][l][r * w + c] = v;
          if (l < L - 1 && r % 2 == 0 && c % 2 == 0) img[l+1][(r / 2) * (w / 2) + c / 2] = v;
        end
    end
  endtask

  function automatic int owner(int s);
    if (s == 0) return 2;
    if (s < 5) return 1;
    return 0;
  endfunction

  // output monitor
  always @(negedge clk_i) begin
    int l, w, h, r, c, e, need;
    string tag;
    if (rst_ni && !finished) begin
      if (out_valid_o) begin
        l = int'(out_level_o);
        beats++;
        chk(l == owner((edge_n - 1) % SLOTS), "R3", l, owner((edge_n - 1) % SLOTS));
        if (l >= L) chk(0, "R2", l, L - 1);
        else if (fr[l] >= NF) chk(0, "R11", fr[l], NF - 1);
        else begin
          w = W >> l;
          h = H >> l;
          r = ix[l] / w;
          c = ix[l] % w;
          e = exp_v[fr[l]][l][ix[l]];
          tag = (l > 0) ? "R6" : ((r == 0 || r == h - 1 || c == 0 || c == w - 1) ? "R5" : "R4");
          chk(int'(out_data_o) == e, tag, int'(out_data_o), e);
          chk(out_sof_o == (ix[l] == 0), "R9", int'(out_sof_o), int'(ix[l] == 0));
          if (l == 0) begin
            need = fr[0] * NPIX + (((r + 2) < H) ? (r + 2) : H) * W;
            chk(acc_seen >= need, "R7", acc_seen, need);
          end
          ix[l]++;
          if (ix[l] == w * h) begin
            ix[l] = 0;
            fr[l]++;
          end
        end
      end
      acc_seen = acc_tot;
    end
  end

  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !finished) wd_hit = 1;
  end

  // stimulus
  initial begin
    bit done_px;
    int exp_rdy;
    void'($urandom(32'd2024));
    for (int f = 0; f < NF; f++)
      for (int p = 0; p < NPIX; p++) begin
        case (f)
          1:       src_v[f][p] = 255;
          2:       src_v[f][p] = (((p / W) + (p % W)) % 2 == 1) ? 255 : 0;
          default: src_v[f][p] = int'($urandom_range(255));
        endcase
      end
    // corner spikes on the last random frame
    src_v[3][0] = 255; src_v[3][W - 1] = 0; src_v[3][NPIX - W] = 0; src_v[3][NPIX - 1] = 255;
    for (int f = 0; f < NF; f++) build(f);
    for (int l = 0; l < L; l++) begin fr[l] = 0; ix[l] = 0; end

    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R10", int'(out_valid_o), 0);
    chk(pix_ready_o == 1'b1, "R10", int'(pix_ready_o), 1);
    rst_ni = 1'b1;

    for (int f = 0; f < NF; f++)
      for (int p = 0; p < NPIX; p++) begin
        while ($urandom_range(3) == 0) begin
          pix_valid_i = 1'b0;
          @(negedge clk_i);
        end
        pix_valid_i = 1'b1;
        pix_data_i  = 8'(src_v[f][p]);
        done_px = 0;
        while (!done_px && !wd_hit) begin
          #1;
          exp_rdy = int'(fr[0] == f && (p / W) <= (ix[0] / W) + 2);
          chk(int'(pix_ready_o) == exp_rdy, "R8", int'(pix_ready_o), exp_rdy);
          if (pix_ready_o) begin
            @(posedge clk_i);
            acc_tot++;
            done_px = 1;
          end
          @(negedge clk_i);
        end
      end
    pix_valid_i = 1'b0;

    wait ((fr[0] == NF && fr[1] == NF && fr[2] == NF) || wd_hit);
    repeat (40) @(negedge clk_i);
    chk(beats == NF * BEATS_PER_FRAME, "R1", beats, NF * BEATS_PER_FRAME);
    chk(fr[1] == NF && ix[1] == 0, "R11", fr[1], NF);
    chk(fr[2] == NF && ix[2] == 0, "R11", fr[2], NF);
    finished = 1;
  end

  initial begin
    wait (finished || wd_hit);
    if (!finished) chk(0, "R11", cyc, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule